// File: doc/BRIEF.md
# Producer-Consumer Link Interrupt Controller

This block supervises the link between an image producer and a video-encoder consumer that share one frame buffer. Software opens or closes each side of the link through a one-bit request register for that side. The peer answers on an acknowledge input. When the requested state and the acknowledge agree, the block records the link as up or down, and it latches a connected or disconnected event.

Three programmable watchdogs guard the handshakes. The first two time the producer connect and the consumer connect. The third times the consumer disconnect handshake. Each watchdog has a 20-bit limit in clock cycles.

A buffer-overflow pulse from the data path is always latched as an event. When auto-resync is off, the overflow also tears down the consumer link at once. A resync-done pulse is latched as a further event. Nine event bits feed one level interrupt, which can be gated by the enable and mask registers. A fixed version word and two status words complete the register map.

Top module: `link_irq_ctrl`

## Requirements
- R1: After reset, the registers read as follows. Interrupt enable (0x1C) is 0x1FF. Mask (0x20) is 0. Event status (0x28) is 0. Each watchdog limit (0x10 producer connect, 0x14 consumer connect, 0x18 consumer disconnect handshake) is 0xFFFFF. The irq output is low.
- R2: The version word at 0x00 returns the VERSION parameter, and writes to it have no effect.
- R3: While the producer request (bit 0 of 0x04) is 1, a high prod_ack completes the connect. The block then sets event bit 5 and link-status bit 0 (at 0x80).
- R4: While the producer request is 0 and the producer is linked, a low prod_ack completes the unlink. The block then sets event bit 6 and clears link-status bit 0.
- R5: Writing 1 to a request register that holds 0 starts that side's connect watchdog. If the link is not up before the count passes the programmed limit, the block sets event bit 2 (producer) or bit 3 (consumer). The watchdog then holds and does not fire again.
- R6: Writing 0 to the consumer request (0x08) while the consumer is linked starts the handshake watchdog. If cons_ack stays high past the limit, the block sets event bit 4. The unlink still completes when cons_ack later falls.
- R7: When the ignore-acknowledge flag (bit 1 of config 0x0C) is set, a consumer request of 1 completes the connect one cycle later, with cons_ack low. The block sets event bit 7 and link-status bit 1, and it sets no timeout.
- R8: An ovfl_evt pulse always sets event bit 0 and increments the overflow count read at 0x84. If auto-resync (bit 0 of 0x0C) is 0 and the consumer is linked, the same edge clears the consumer request and the link and sets event bit 8. If auto-resync is 1, the consumer link is kept.
- R9: irq is high exactly when some event bit is set, enabled in 0x1C and not masked in 0x20.
- R10: Writing 1 to a bit of the clear register (0x24) clears that event bit. An event that arrives in the same cycle as the clear wins, and the bit stays set.
- R11: A resync_done pulse sets event bit 1.
- R12: Watchdog limit registers keep only their low 20 bits, and the upper bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| prod_ack | input | 1 | Producer link acknowledge, level |
| cons_ack | input | 1 | Consumer link acknowledge, level |
| ovfl_evt | input | 1 | Buffer overflow pulse |
| resync_done | input | 1 | Resync finished pulse |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is event latching and the clear register. The bench raises resync_done on the same clock edge as a write of 1 to clear bit 1. It then reads the status, which must still show bit 1.

The second pair is an overflow and the consumer link bookkeeping. The overflow pulse arrives while the consumer is linked. The bench judges the edge from the status word: both the overflow and consumer-disconnect bits must be set, the consumer request must read back as 0, and the link-status bit must be clear when auto-resync is off. When auto-resync is on, only the overflow bit may be set.

// File: rtl/link_irq_pkg.sv
package link_irq_pkg;
   localparam int NEVT = 9;
   // event bit positions
   localparam int EV_OVFL  = 0;
   localparam int EV_RSYNC = 1;
   localparam int EV_PTMO  = 2;
   localparam int EV_CTMO  = 3;
   localparam int EV_HTMO  = 4;
   localparam int EV_PCON  = 5;
   localparam int EV_PDIS  = 6;
   localparam int EV_CCON  = 7;
   localparam int EV_CDIS  = 8;
   // register offsets
   localparam logic [7:0] A_VER  = 8'h00;
   localparam logic [7:0] A_PREQ = 8'h04;
   localparam logic [7:0] A_CREQ = 8'h08;
   localparam logic [7:0] A_CFG  = 8'h0C;
   localparam logic [7:0] A_WD0  = 8'h10;
   localparam logic [7:0] A_WD1  = 8'h14;
   localparam logic [7:0] A_WD2  = 8'h18;
   localparam logic [7:0] A_EN   = 8'h1C;
   localparam logic [7:0] A_MSK  = 8'h20;
   localparam logic [7:0] A_CLR  = 8'h24;
   localparam logic [7:0] A_ST   = 8'h28;
   localparam logic [7:0] A_LNK  = 8'h80;
   localparam logic [7:0] A_OVF  = 8'h84;
endpackage

// File: rtl/link_wdog.sv
module link_wdog #(
   parameter int W = 20
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         run,
   input  logic [W-1:0] limit,
   output logic         expire
);
   logic [W-1:0] cnt;
   logic         armed;

   assign expire = armed && run && !start && (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         armed <= 1'b0;
      end else if (start) begin
         cnt   <= '0;
         armed <= 1'b1;
      end else if (armed) begin
         if (!run || cnt == limit) armed <= 1'b0;
         else                      cnt   <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/link_evt_bank.sv
module link_evt_bank #(
   parameter int N = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   input  logic [N-1:0] en,
   input  logic [N-1:0] msk,
   output logic [N-1:0] st,
   output logic         irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= '0;
      else        st <= (st & ~clr) | set;
   end

   assign irq = |(st & en & ~msk);
endmodule

// File: rtl/link_irq_ctrl.sv
module link_irq_ctrl
   import link_irq_pkg::*;
#(
   parameter int          ADDR_W  = 8,
   parameter int          DATA_W  = 32,
   parameter int          WD_W    = 20,
   parameter int          OVF_W   = 8,
   parameter logic [31:0] VERSION = 32'h0001_0200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              prod_ack,
   input  logic              cons_ack,
   input  logic              ovfl_evt,
   input  logic              resync_done,
   output logic              irq
);
   localparam int NWD = 3;
   localparam logic [WD_W-1:0] WD_INIT = {WD_W{1'b1}};

   if (WD_W < 1 || WD_W > DATA_W) begin : g_bad_wd
      $error("WD_W must lie in 1..DATA_W");
   end
   if (ADDR_W < 8 || DATA_W < 32 || OVF_W < 1 || OVF_W > DATA_W) begin : g_bad_bus
      $error("bus or counter width out of range");
   end

   logic            prod_req, cons_req, prod_lnk, cons_lnk;
   logic [2:0]      cfg;
   logic [WD_W-1:0] wd_lim [NWD];
   logic [NEVT-1:0] en, msk, st, ev_set, ev_clr;
   logic [OVF_W-1:0] ovf_cnt;
   logic            wd_start [NWD];
   logic            wd_run   [NWD];
   logic            wd_exp   [NWD];

   wire cfg_auto = cfg[0];
   wire cfg_ign  = cfg[1];
   wire [7:0] a8 = reg_addr[7:0];
   wire wr_p     = reg_we && a8 == A_PREQ;
   wire wr_c     = reg_we && a8 == A_CREQ;

   // link transitions
   wire drop   = ovfl_evt && !cfg_auto && cons_lnk;
   wire p_up   = prod_req && !prod_lnk && prod_ack;
   wire p_down = !prod_req && prod_lnk && !prod_ack;
   wire c_up   = cons_req && !cons_lnk && (cons_ack || cfg_ign);
   wire c_down = drop || (!cons_req && cons_lnk && (!cons_ack || cfg_ign));

   assign wd_start[0] = wr_p && reg_wdata[0] && !prod_req;
   assign wd_run[0]   = prod_req && !prod_lnk;
   assign wd_start[1] = wr_c && reg_wdata[0] && !cons_req;
   assign wd_run[1]   = cons_req && !cons_lnk;
   assign wd_start[2] = wr_c && !reg_wdata[0] && cons_req && cons_lnk;
   assign wd_run[2]   = cons_lnk && !cons_req;

   for (genvar g = 0; g < NWD; g++) begin : g_wd
      link_wdog #(.W(WD_W)) u_wd (
         .clk(clk), .rst_n(rst_n), .start(wd_start[g]), .run(wd_run[g]),
         .limit(wd_lim[g]), .expire(wd_exp[g]));
   end

   always_comb begin
      ev_set           = '0;
      ev_set[EV_OVFL]  = ovfl_evt;
      ev_set[EV_RSYNC] = resync_done;
      ev_set[EV_PTMO]  = wd_exp[0];
      ev_set[EV_CTMO]  = wd_exp[1];
      ev_set[EV_HTMO]  = wd_exp[2];
      ev_set[EV_PCON]  = p_up;
      ev_set[EV_PDIS]  = p_down;
      ev_set[EV_CCON]  = c_up;
      ev_set[EV_CDIS]  = c_down;
      ev_clr = (reg_we && a8 == A_CLR) ? reg_wdata[NEVT-1:0] : '0;
   end

   link_evt_bank #(.N(NEVT)) u_evt (
      .clk(clk), .rst_n(rst_n), .set(ev_set), .clr(ev_clr),
      .en(en), .msk(msk), .st(st), .irq(irq));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prod_req <= 1'b0;
         cons_req <= 1'b0;
         prod_lnk <= 1'b0;
         cons_lnk <= 1'b0;
         cfg      <= '0;
         en       <= '1;
         msk      <= '0;
         ovf_cnt  <= '0;
         for (int i = 0; i < NWD; i++) wd_lim[i] <= WD_INIT;
      end else begin
         if (wr_p) prod_req <= reg_wdata[0];
         if (p_up)        prod_lnk <= 1'b1;
         else if (p_down) prod_lnk <= 1'b0;
         if (drop) begin
            cons_req <= 1'b0;
            cons_lnk <= 1'b0;
         end else begin
            if (wr_c) cons_req <= reg_wdata[0];
            if (c_up)        cons_lnk <= 1'b1;
            else if (c_down) cons_lnk <= 1'b0;
         end
         if (ovfl_evt) ovf_cnt <= ovf_cnt + 1'b1;
         if (reg_we) begin
            case (a8)
               A_CFG: cfg       <= reg_wdata[2:0];
               A_WD0: wd_lim[0] <= reg_wdata[WD_W-1:0];
               A_WD1: wd_lim[1] <= reg_wdata[WD_W-1:0];
               A_WD2: wd_lim[2] <= reg_wdata[WD_W-1:0];
               A_EN:  en        <= reg_wdata[NEVT-1:0];
               A_MSK: msk       <= reg_wdata[NEVT-1:0];
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (a8)
         A_VER:  reg_rdata = DATA_W'(VERSION);
         A_PREQ: reg_rdata[0] = prod_req;
         A_CREQ: reg_rdata[0] = cons_req;
         A_CFG:  reg_rdata[2:0] = cfg;
         A_WD0:  reg_rdata[WD_W-1:0] = wd_lim[0];
         A_WD1:  reg_rdata[WD_W-1:0] = wd_lim[1];
         A_WD2:  reg_rdata[WD_W-1:0] = wd_lim[2];
         A_EN:   reg_rdata[NEVT-1:0] = en;
         A_MSK:  reg_rdata[NEVT-1:0] = msk;
         A_ST:   reg_rdata[NEVT-1:0] = st;
         A_LNK:  reg_rdata[1:0] = {cons_lnk, prod_lnk};
         A_OVF:  reg_rdata[OVF_W-1:0] = ovf_cnt;
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/link_irq_ctrl_chk.sv
module link_irq_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       irq,
   input logic [8:0] st,
   input logic [8:0] en,
   input logic       prod_lnk,
   input logic       cons_lnk,
   input logic       cons_req,
   input logic       cfg_auto,
   input logic       cfg_ign,
   input logic       ovfl_evt,
   input logic       resync_done
);
   p_prod_cnct_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prod_lnk) |-> st[5]);

   p_ign_cnct_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_ign && cons_req && !cons_lnk |=> cons_lnk && st[7]);

   p_ovfl_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ovfl_evt && !cfg_auto && cons_lnk |=> !cons_lnk && !cons_req && st[8] && st[0]);

   p_ovfl_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ovfl_evt && cfg_auto && cons_lnk && cons_req |=> cons_lnk && st[0]);

   p_no_en_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      en == '0 |-> !irq);

   p_no_st_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      st == '0 |-> !irq);

   p_rsync_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      resync_done |=> st[1]);
endmodule

bind link_irq_ctrl link_irq_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .irq(irq), .st(st), .en(en),
   .prod_lnk(prod_lnk), .cons_lnk(cons_lnk), .cons_req(cons_req),
   .cfg_auto(cfg[0]), .cfg_ign(cfg[1]),
   .ovfl_evt(ovfl_evt), .resync_done(resync_done));

// File: tb/link_irq_ctrl_test.sv
module link_irq_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        prod_ack = 1'b0, cons_ack = 1'b0;
   logic        ovfl_evt = 1'b0, resync_done = 1'b0;
   logic        irq;

   int total = 0, bad = 0;
   bit done = 0;

   typedef struct {
      bit          is_irq;
      logic [31:0] exp;
      logic [31:0] m;
      string       tag;
   } item_t;
   item_t q[$];

   always #5 clk = ~clk;

   link_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .prod_ack(prod_ack),
      .cons_ack(cons_ack), .ovfl_evt(ovfl_evt), .resync_done(resync_done),
      .irq(irq));

   // monitor: pops expectations and compares them 2 ns after the driving edge
   initial forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it = q.pop_front();
         act = it.is_irq ? {31'b0, irq} : (reg_rdata & it.m);
         total++;
         if (act !== it.exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] m,
                     input logic [31:0] e, input string tag);
      item_t it;
      @(negedge clk);
      reg_addr = a;
      it.is_irq = 1'b0; it.exp = e; it.m = m; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic chk_irq(input logic e, input string tag);
      item_t it;
      @(negedge clk);
      it.is_irq = 1'b1; it.exp = {31'b0, e}; it.m = '1; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      // R1 reset state
      rd(8'h1C, 32'hFFFF_FFFF, 32'h1FF, "R1 enable");
      rd(8'h20, 32'hFFFF_FFFF, 32'h0, "R1 mask");
      rd(8'h28, 32'hFFFF_FFFF, 32'h0, "R1 status");
      rd(8'h10, 32'hFFFF_FFFF, 32'hFFFFF, "R1 wd0");
      rd(8'h18, 32'hFFFF_FFFF, 32'hFFFFF, "R1 wd2");
      chk_irq(1'b0, "R1 irq");
      // R2 version
      wr(8'h00, 32'hDEAD_BEEF);
      rd(8'h00, 32'hFFFF_FFFF, 32'h0001_0200, "R2 version");
      // R12 limit width
      wr(8'h10, 32'hABC0_0006);
      rd(8'h10, 32'hFFFF_FFFF, 32'h6, "R12 wd0 width");
      // R5 producer connect timeout
      wr(8'h04, 32'h1);
      idle(2);
      rd(8'h28, 32'h4, 32'h0, "R5 prod tmo early");
      idle(10);
      rd(8'h28, 32'h1FF, 32'h4, "R5 prod tmo set");
      chk_irq(1'b1, "R9 irq on tmo");
      wr(8'h24, 32'h4);
      rd(8'h28, 32'h1FF, 32'h0, "R10 clear");
      chk_irq(1'b0, "R9 irq after clear");
      // R3 producer connect
      prod_ack = 1'b1;
      idle(3);
      rd(8'h28, 32'h1FF, 32'h20, "R3 prod connected evt");
      rd(8'h80, 32'h3, 32'h1, "R3 prod link status");
      wr(8'h24, 32'h1FF);
      // R4 producer disconnect
      wr(8'h04, 32'h0);
      prod_ack = 1'b0;
      idle(3);
      rd(8'h28, 32'h1FF, 32'h40, "R4 prod disconnected evt");
      rd(8'h80, 32'h3, 32'h0, "R4 prod link status");
      wr(8'h24, 32'h1FF);
      // consumer connect with ack
      wr(8'h14, 32'h6);
      cons_ack = 1'b1;
      wr(8'h08, 32'h1);
      idle(12);
      rd(8'h28, 32'h1FF, 32'h80, "R5 cons connect, no tmo");
      rd(8'h80, 32'h3, 32'h2, "R5 cons link status");
      wr(8'h24, 32'h1FF);
      // R8 overflow, auto-resync off
      @(negedge clk); ovfl_evt = 1'b1;
      @(negedge clk); ovfl_evt = 1'b0;
      rd(8'h28, 32'h1FF, 32'h101, "R8 ovfl drops link evt");
      rd(8'h08, 32'h1, 32'h0, "R8 cons request cleared");
      rd(8'h80, 32'h3, 32'h0, "R8 cons link dropped");
      wr(8'h24, 32'h1FF);
      // R8 overflow, auto-resync on
      wr(8'h0C, 32'h1);
      wr(8'h08, 32'h1);
      idle(2);
      wr(8'h24, 32'h1FF);
      @(negedge clk); ovfl_evt = 1'b1;
      @(negedge clk); ovfl_evt = 1'b0;
      rd(8'h28, 32'h1FF, 32'h001, "R8 auto keeps link evt");
      rd(8'h80, 32'h3, 32'h2, "R8 auto keeps link");
      rd(8'h84, 32'hFF, 32'h2, "R8 overflow count");
      wr(8'h24, 32'h1FF);
      // R6 handshake timeout
      wr(8'h18, 32'h4);
      wr(8'h08, 32'h0);
      idle(10);
      rd(8'h28, 32'h10, 32'h10, "R6 handshake tmo");
      rd(8'h80, 32'h3, 32'h2, "R6 still linked");
      cons_ack = 1'b0;
      idle(2);
      rd(8'h28, 32'h1FF, 32'h110, "R6 unlink after tmo");
      wr(8'h24, 32'h1FF);
      // R7 ignore acknowledge
      wr(8'h0C, 32'h2);
      wr(8'h08, 32'h1);
      idle(10);
      rd(8'h28, 32'h1FF, 32'h80, "R7 ignore ack connect");
      rd(8'h80, 32'h3, 32'h2, "R7 link status");
      rd(8'h0C, 32'h7, 32'h2, "R7 cfg readback");
      // R5 consumer connect timeout
      wr(8'h0C, 32'h0);
      wr(8'h08, 32'h0);
      idle(2);
      wr(8'h24, 32'h1FF);
      wr(8'h08, 32'h1);
      idle(2);
      rd(8'h28, 32'h8, 32'h0, "R5 cons tmo early");
      idle(10);
      rd(8'h28, 32'h1FF, 32'h8, "R5 cons tmo set");
      wr(8'h24, 32'h1FF);
      wr(8'h08, 32'h0);
      // R11 / R9 resync and gating
      @(negedge clk); resync_done = 1'b1;
      @(negedge clk); resync_done = 1'b0;
      rd(8'h28, 32'h1FF, 32'h2, "R11 resync evt");
      chk_irq(1'b1, "R9 irq enabled");
      wr(8'h20, 32'h2);
      chk_irq(1'b0, "R9 irq masked");
      wr(8'h20, 32'h0);
      wr(8'h1C, 32'h1FD);
      chk_irq(1'b0, "R9 irq disabled");
      wr(8'h1C, 32'h1FF);
      // R10 set wins over same-cycle clear
      @(negedge clk);
      resync_done = 1'b1; reg_we = 1'b1; reg_addr = 8'h24; reg_wdata = 32'h2;
      @(negedge clk);
      resync_done = 1'b0; reg_we = 1'b0;
      rd(8'h28, 32'h2, 32'h2, "R10 set wins over clear");
      wr(8'h24, 32'h2);
      rd(8'h28, 32'h1FF, 32'h0, "R10 clear after");
      idle(3);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule